// File: doc/BRIEF.md
# Line Driver Enable and Clock Activity Monitor

This block decides, per line channel, whether the transmit line driver is allowed to drive or must stay in high impedance. It watches two clocks, the transmit data clock and the reference clock, by sampling them with a faster sampling clock. It holds a 4-bit line configuration code written by the host. The driver is enabled only when both clocks are seen as running and the configuration code is not one of the two tri-state codes.

The block also produces the data-path override selects that sit around the driver and receiver. The transmit all-ones select follows a request input. The two local loopback control bits are decoded into loopback selects. When both loopback bits are set, no loopback is selected and the receive path is forced to an unframed all-ones pattern instead.

Every output is registered in the sampling clock domain, so a configuration write or a clock state change never produces a glitch on the driver enable.

Top module: `txdrv_ctrl`

## Requirements
- R1: When no rising edge of `tx_clk_i` is seen for LOSS_CYCLES consecutive sample cycles, the transmit clock is declared absent, and `drv_en_o` and `clk_ok_o` go to 0.
- R2: When no rising edge of `ref_clk_i` is seen for LOSS_CYCLES consecutive sample cycles, the reference clock is declared absent, and `drv_en_o` and `clk_ok_o` go to 0.
- R3: A stored configuration code whose bits 3, 2 and 1 are all 1 (4'b1110 or 4'b1111) forces `drv_en_o` to 0, whatever bit 0 holds. Every other code allows the driver to be enabled.
- R4: While `rst_ni` is low and right after reset, the configuration register holds 4'b1110, both clocks count as absent, and every output is 0.
- R5: An absent clock is declared present after ACQ_EDGES rising edges. A run of LOSS_CYCLES edgeless sample cycles restarts this count. A monitored rising edge that falls between two sample edges is counted at the third sample edge after it, and `clk_ok_o` and `drv_en_o` show the resulting monitor state one sample edge later.
- R6: `clk_ok_o` is 1 exactly when both clocks are declared present. `drv_en_o` is never 1 while `clk_ok_o` is 0.
- R7: When `lloop_a_i` and `lloop_b_i` are both 1, `rx_ones_o` becomes 1 and `lb_sel_o` becomes 2'b00 at the next sample edge.
- R8: `lb_sel_o[0]` is 1 when only `lloop_a_i` is 1, and `lb_sel_o[1]` is 1 when only `lloop_b_i` is 1. Both bits are 0 when neither loopback bit is set. Each change appears one sample edge after the input change.
- R9: `tx_ones_o` equals `tx_ones_req_i` as it was sampled at the previous sample edge.
- R10: A write (`cfg_we_i` high at sample edge P) stores `cfg_wdata_i` at P. `drv_en_o` reflects the new code at sample edge P+1 and changes only on sample edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk_i | input | 1 | Fast sampling clock; all outputs are registered on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_clk_i | input | 1 | Transmit data clock being monitored |
| ref_clk_i | input | 1 | Reference clock being monitored |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Line configuration code to store |
| lloop_a_i | input | 1 | First local loopback control bit |
| lloop_b_i | input | 1 | Second local loopback control bit |
| tx_ones_req_i | input | 1 | Transmit all-ones request |
| drv_en_o | output | 1 | Line driver enable; 0 means high impedance |
| clk_ok_o | output | 1 | Both monitored clocks present |
| tx_ones_o | output | 1 | Transmit all-ones override select |
| rx_ones_o | output | 1 | Receive all-ones override select |
| lb_sel_o | output | 2 | Loopback select, bit 0 for path A and bit 1 for path B |

## Verification
The bench builds the block with LOSS_CYCLES = 16 and ACQ_EDGES = 4. With these values, loss, reacquisition and an aborted reacquisition (two edges followed by a long gap) each happen within a few dozen sample cycles. Both monitored clocks are derived from the sampling clock with different half-periods of 3 and 2 sample cycles. Each monitored edge therefore falls at a known point, and a behavioural model with an edge-history queue can predict every output on every cycle.

// File: rtl/txdrv_pkg.sv
package txdrv_pkg;
  localparam int CFG_W = 4;
  localparam logic [CFG_W-1:0] CFG_RST = 4'b1110;

  // codes 111x keep the driver in high impedance
  function automatic logic cfg_tristate(input logic [CFG_W-1:0] cfg);
    return cfg[3:1] == 3'b111;
  endfunction

  typedef struct packed {
    logic       tx_ones;
    logic       rx_ones;
    logic [1:0] lb_sel;
  } ovr_t;
endpackage

// File: rtl/txdrv_clk_mon.sv
module txdrv_clk_mon #(
  parameter int LOSS_CYCLES = 64,
  parameter int ACQ_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic samp_clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  output logic ok_o
);
  localparam int IDLE_W = $clog2(LOSS_CYCLES + 1);
  localparam int ACQ_W  = $clog2(ACQ_EDGES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOSS_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_FULL = IDLE_W'(LOSS_CYCLES);
  localparam logic [ACQ_W-1:0]  ACQ_LAST  = ACQ_W'(ACQ_EDGES - 1);

  logic                tog_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                edge_w, expire_w;
  logic [IDLE_W-1:0]   idle_q;
  logic [ACQ_W-1:0]    acq_q;
  logic                ok_q;

  // toggles once per monitored rising edge
  always_ff @(posedge mon_clk_i or negedge rst_ni)
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;

  // top bit is the previous synchronised value
  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};

  assign edge_w   = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign expire_w = !edge_w && (idle_q == IDLE_LAST);

  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni)              idle_q <= '0;
    else if (edge_w)          idle_q <= '0;
    else if (idle_q != IDLE_FULL) idle_q <= idle_q + 1'b1;

  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      acq_q <= '0;
    end else if (expire_w) begin
      ok_q  <= 1'b0;
      acq_q <= '0;
    end else if (edge_w && !ok_q) begin
      if (acq_q == ACQ_LAST) begin
        ok_q  <= 1'b1;
        acq_q <= '0;
      end else begin
        acq_q <= acq_q + 1'b1;
      end
    end

  assign ok_o = ok_q;

  AST_IDLE_MEANS_ABSENT: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    (idle_q == IDLE_FULL) |-> !ok_q); // R1
  AST_PRESENT_NEEDS_EDGE: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> $past(edge_w)); // R5
  AST_ACQ_IN_RANGE: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    acq_q <= ACQ_LAST); // R5
endmodule

// File: rtl/txdrv_ovr.sv
module txdrv_ovr
  import txdrv_pkg::*;
(
  input  logic samp_clk_i,
  input  logic rst_ni,
  input  logic lloop_a_i,
  input  logic lloop_b_i,
  input  logic tx_ones_req_i,
  output ovr_t ovr_o
);
  ovr_t ovr_d, ovr_q;

  always_comb begin
    ovr_d.tx_ones = tx_ones_req_i;
    ovr_d.rx_ones = lloop_a_i && lloop_b_i;
    // both bits set selects neither loopback
    ovr_d.lb_sel  = {lloop_b_i && !lloop_a_i, lloop_a_i && !lloop_b_i};
  end

  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni) ovr_q <= '0;
    else         ovr_q <= ovr_d;

  assign ovr_o = ovr_q;

  AST_RX_ONES_NO_LOOP: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    ovr_q.rx_ones |-> (ovr_q.lb_sel == 2'b00)); // R7
  AST_LOOP_ONEHOT: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    $onehot0(ovr_q.lb_sel)); // R8
endmodule

// File: rtl/txdrv_ctrl.sv
module txdrv_ctrl
  import txdrv_pkg::*;
#(
  parameter int LOSS_CYCLES = 64,
  parameter int ACQ_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             samp_clk_i,
  input  logic             rst_ni,
  input  logic             tx_clk_i,
  input  logic             ref_clk_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             lloop_a_i,
  input  logic             lloop_b_i,
  input  logic             tx_ones_req_i,
  output logic             drv_en_o,
  output logic             clk_ok_o,
  output logic             tx_ones_o,
  output logic             rx_ones_o,
  output logic [1:0]       lb_sel_o
);
  localparam int NUM_MON = 2;

  logic [NUM_MON-1:0] mon_clk, mon_ok;
  logic [CFG_W-1:0]   cfg_q;
  logic               drv_en_q, clk_ok_q;
  ovr_t               ovr;

  assign mon_clk = {ref_clk_i, tx_clk_i};

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    txdrv_clk_mon #(
      .LOSS_CYCLES(LOSS_CYCLES),
      .ACQ_EDGES  (ACQ_EDGES),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .samp_clk_i(samp_clk_i),
      .rst_ni    (rst_ni),
      .mon_clk_i (mon_clk[g]),
      .ok_o      (mon_ok[g])
    );
  end

  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;

  always_ff @(posedge samp_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      drv_en_q <= 1'b0;
      clk_ok_q <= 1'b0;
    end else begin
      drv_en_q <= (&mon_ok) && !cfg_tristate(cfg_q);
      clk_ok_q <= &mon_ok;
    end

  txdrv_ovr u_ovr (
    .samp_clk_i   (samp_clk_i),
    .rst_ni       (rst_ni),
    .lloop_a_i    (lloop_a_i),
    .lloop_b_i    (lloop_b_i),
    .tx_ones_req_i(tx_ones_req_i),
    .ovr_o        (ovr)
  );

  assign drv_en_o  = drv_en_q;
  assign clk_ok_o  = clk_ok_q;
  assign tx_ones_o = ovr.tx_ones;
  assign rx_ones_o = ovr.rx_ones;
  assign lb_sel_o  = ovr.lb_sel;

  AST_CFG_TRISTATE: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    cfg_tristate(cfg_q) |=> !drv_en_o); // R3
  AST_DRV_NEEDS_CLKS: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    drv_en_o |-> clk_ok_o); // R6
  AST_LOSS_DROPS_OK: assert property (@(posedge samp_clk_i) disable iff (!rst_ni)
    !(&mon_ok) |=> !clk_ok_o); // R1
endmodule

// File: tb/txdrv_ctrl_bench.sv
module txdrv_ctrl_bench;
  localparam int LOSS = 16;
  localparam int ACQ  = 4;

  logic samp_clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_clk = 1'b0, ref_clk = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'b0;
  logic la = 1'b0, lb = 1'b0, txreq = 1'b0;
  logic drv_en, clk_ok, tx_ones, rx_ones;
  logic [1:0] lb_sel;

  int checks = 0, fails = 0, cycles = 0;

  txdrv_ctrl #(.LOSS_CYCLES(LOSS), .ACQ_EDGES(ACQ)) u_txdrv_ctrl (
    .samp_clk_i(samp_clk), .rst_ni(rst_n), .tx_clk_i(tx_clk), .ref_clk_i(ref_clk),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .lloop_a_i(la), .lloop_b_i(lb),
    .tx_ones_req_i(txreq), .drv_en_o(drv_en), .clk_ok_o(clk_ok),
    .tx_ones_o(tx_ones), .rx_ones_o(rx_ones), .lb_sel_o(lb_sel));

  always #10 samp_clk = ~samp_clk;

  // monitored clock generation, driven at sample negedges
  bit run_tx = 0, run_ref = 0;
  int tx_cnt = 0, ref_cnt = 0, tx_rises = 0, ref_rises = 0;
  always @(negedge samp_clk) begin
    if (run_tx) begin
      tx_cnt++;
      if (tx_cnt == 3) begin
        tx_cnt = 0; tx_clk = ~tx_clk;
        if (tx_clk) tx_rises++;
      end
    end
    if (run_ref) begin
      ref_cnt++;
      if (ref_cnt == 2) begin
        ref_cnt = 0; ref_clk = ~ref_clk;
        if (ref_clk) ref_rises++;
      end
    end
  end

  // reference model
  int tx_seen = 0, ref_seen = 0;
  bit hq_tx[$], hq_ref[$];
  int m_idle[2], m_acq[2];
  bit m_ok[2];
  bit m_ok_prev_clk;
  logic [3:0] m_cfg = 4'b1110;
  bit e_drv = 0, e_clk = 0, e_txo = 0, e_rxo = 0;
  bit [1:0] e_lb = 0;

  task automatic mon_step(input int k, input bit ev);
    if (!ev && m_idle[k] == LOSS - 1) begin
      m_ok[k] = 0; m_acq[k] = 0;
    end else if (ev && !m_ok[k]) begin
      m_acq[k]++;
      if (m_acq[k] == ACQ) begin m_ok[k] = 1; m_acq[k] = 0; end
    end
    if (ev) m_idle[k] = 0;
    else if (m_idle[k] < LOSS) m_idle[k]++;
  endtask

  always @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      hq_tx.delete(); hq_ref.delete();
      m_idle = '{0, 0}; m_acq = '{0, 0}; m_ok = '{0, 0};
      m_cfg = 4'b1110;
      e_drv = 0; e_clk = 0; e_txo = 0; e_rxo = 0; e_lb = 0;
      tx_seen = tx_rises; ref_seen = ref_rises;
    end else begin
      bit etx, eref;
      etx = 0; eref = 0;
      hq_tx.push_back(tx_rises != tx_seen);   tx_seen = tx_rises;
      hq_ref.push_back(ref_rises != ref_seen); ref_seen = ref_rises;
      if (hq_tx.size() > 2) etx = hq_tx.pop_front();
      if (hq_ref.size() > 2) eref = hq_ref.pop_front();
      e_drv = m_ok[0] && m_ok[1] && !(m_cfg[3:1] == 3'b111);
      e_clk = m_ok[0] && m_ok[1];
      e_txo = txreq;
      e_rxo = la && lb;
      e_lb  = {lb && !la, la && !lb};
      mon_step(0, etx);
      mon_step(1, eref);
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge samp_clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R4", "drv_en", drv_en, 0);
      chk("R4", "clk_ok", clk_ok, 0);
      chk("R4", "outputs", {tx_ones, rx_ones, lb_sel}, 0);
    end else begin
      string dtag;
      if (!m_ok[0] && !e_clk) dtag = "R1";
      else if (!m_ok[1] && !e_clk) dtag = "R2";
      else if (m_cfg[3:1] == 3'b111) dtag = "R3";
      else dtag = "R10";
      chk(dtag, "drv_en", drv_en, e_drv);
      chk((e_clk != m_ok_prev_clk) ? "R5" : "R6", "clk_ok", clk_ok, e_clk);
      chk("R9", "tx_ones", tx_ones, e_txo);
      chk("R7", "rx_ones", rx_ones, e_rxo);
      chk("R8", "lb_sel", lb_sel, e_lb);
      m_ok_prev_clk = e_clk;
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge samp_clk);
  endtask

  task automatic set_cfg(input logic [3:0] v);
    @(negedge samp_clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge samp_clk); cfg_we = 1'b0;
  endtask

  task automatic set_lb(input bit a, input bit b);
    @(negedge samp_clk); la = a; lb = b;
    step(3);
  endtask

  initial begin
    m_ok_prev_clk = 0;
    step(3);                       // R4 during reset
    @(negedge samp_clk); rst_n = 1'b1;
    step(5);                       // R4 after reset, clocks idle
    run_tx = 1; run_ref = 1;
    step(60);                      // R5 acquisition, R3 reset code still tri-states
    set_cfg(4'b0000); step(10);    // R10
    set_cfg(4'b1111); step(5);     // R3
    set_cfg(4'b1101); step(5);
    set_cfg(4'b0111); step(5);
    run_tx = 0; step(40);          // R1
    run_tx = 1; step(12);          // partial reacquisition
    run_tx = 0; step(30);          // R5 restart of the count
    run_tx = 1; step(50);
    run_ref = 0; step(30);         // R2
    run_ref = 1; step(40);
    set_lb(1, 0); set_lb(0, 1); set_lb(1, 1); set_lb(0, 0); // R7 R8
    set_lb(1, 1); set_lb(1, 0);
    @(negedge samp_clk); txreq = 1'b1; step(3);              // R9
    @(negedge samp_clk); txreq = 1'b0; step(3);
    set_cfg(4'b1110); step(5);     // R3
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule